// File: doc/BRIEF.md
# Profiling Filter Register Access Decider

This block is a purely combinational priority decoder placed beside the system-register access path of a core. For every read or write aimed at one protected profiling-control register, it works out which of five outcomes applies. The outcomes are an undefined-instruction exception, a trap to level 2, a trap to level 3, a redirect of the access to a memory slot, or a plain access to the register. Its inputs are the current exception level, the access direction, the debug-halt state and the trap and ownership controls held elsewhere in the core. The exception-entry logic and the register itself consume the result.

The checks form a chain in a fixed order. At level 1 the order is as follows. First comes a debug-halt case that ranks ahead of everything else. Next come the fine-grained level-2 trap and then the coarse level-2 profiling trap. After those comes the level-3 buffer-ownership check, and a halted core with secure debug disabled turns that trap into undefined. Last comes a nested-virtualization pattern that sends the access to a memory slot. Level 2 keeps only the halt case and the ownership check. Level 0 is always refused and level 3 always reaches the register.

Top module: `prof_reg_access_decide`

## Requirements
- R1: Any access with `cur_lvl` = 0 gives `res_undef`, whatever the other inputs are.
- R2: Any access with `cur_lvl` = 3 gives `res_direct`, whatever the other inputs are.
- R3: The ownership check fails when `lvl3_present`=1 and `buf_owner` differs from 2'b01 (with `nonsecure`=0) or from 2'b11 (with `nonsecure`=1). At level 1 or 2, if `dbg_halted`, `sec_dbg_off` and `halt_undef_first` are all 1 and the ownership check fails, the result is `res_undef`. This case ranks ahead of every level-2 trap.
- R4: At level 1, with `lvl2_enabled`=1 and with either `lvl3_present`=0 or `fine_trap_en`=1, the result is `res_trap_lvl2`. A read (`is_write`=0) needs `fine_rd_trap`=1 for this and a write needs `fine_wr_trap`=1. The bit for the other direction has no effect.
- R5: At level 1, with `lvl2_enabled`=1 and `coarse_prof_trap`=1, the result is `res_trap_lvl2` when the fine-grained trap has not fired. This check ranks ahead of the ownership check.
- R6: At level 1 or 2, when no earlier check fires and the ownership check fails, the result is `res_trap_lvl3`. It is `res_undef` instead when `dbg_halted`=1 and `sec_dbg_off`=1.
- R7: At level 1, when no trap fires, `lvl2_enabled`=1 and `nest_virt` (bit 2, bit 1, bit 0) matches 1x1, the result is `res_redirect` and `redirect_ofs` = 12'h830. `redirect_ofs` is 0 for every other outcome.
- R8: At level 2 the fine-grained trap, the coarse trap and the redirect never apply.
- R9: `trap_class` is 6'h18 whenever `res_trap_lvl2` or `res_trap_lvl3` is 1, and 0 otherwise.
- R10: Exactly one of `res_undef`, `res_trap_lvl2`, `res_trap_lvl3`, `res_redirect` and `res_direct` is 1 for every input combination.
- R11: With `lvl3_present`=0, `nonsecure` and `buf_owner` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cur_lvl | input | 2 | Current exception level, 0 to 3 |
| is_write | input | 1 | 1 for a write, 0 for a read |
| dbg_halted | input | 1 | Core is halted in debug state |
| sec_dbg_off | input | 1 | Secure debug is disabled |
| halt_undef_first | input | 1 | Implementation choice: the halted-undefined case ranks first |
| lvl3_present | input | 1 | Level 3 is implemented |
| lvl2_enabled | input | 1 | Level 2 is enabled in the current state |
| nonsecure | input | 1 | 1 when the current security state is non-secure |
| buf_owner | input | 2 | Profiling-buffer ownership field |
| fine_trap_en | input | 1 | Fine-grained trap enable held by level 3 |
| fine_rd_trap | input | 1 | Fine-grained trap bit for reads |
| fine_wr_trap | input | 1 | Fine-grained trap bit for writes |
| coarse_prof_trap | input | 1 | Coarse level-2 profiling trap bit |
| nest_virt | input | 3 | Nested-virtualization controls, bit 2 down to bit 0 |
| res_undef | output | 1 | Access is undefined |
| res_trap_lvl2 | output | 1 | Access traps to level 2 |
| res_trap_lvl3 | output | 1 | Access traps to level 3 |
| res_redirect | output | 1 | Access goes to the memory slot |
| res_direct | output | 1 | Access reaches the register |
| trap_class | output | 6 | Syndrome exception class when trapping |
| redirect_ofs | output | 12 | Byte offset of the memory slot on redirect |

## Verification
The decoder is driven with patterns that set two conditions at once and differ in only one control, so each pair shows which of two neighbouring checks wins. Examples are halt-undefined against the fine trap, fine trap against coarse trap, coarse trap against the ownership trap, and ownership trap against redirect. Read and write pairs with only the other direction's trap bit set show that direction selects the right bit. Level 0, level 2 and level 3 get the same aggressive inputs as level 1, which shows the chain is cut per level. Patterns with level 3 absent and a bad owner or security state show those inputs are masked.

// File: rtl/prof_access_pkg.sv
package prof_access_pkg;

   localparam int LVL_W = 2;

   typedef enum logic [LVL_W-1:0] {
      LVL_0 = 2'd0,
      LVL_1 = 2'd1,
      LVL_2 = 2'd2,
      LVL_3 = 2'd3
   } lvl_e;

   typedef enum logic [2:0] {
      OUT_UNDEF,
      OUT_TRAP2,
      OUT_TRAP3,
      OUT_REDIR,
      OUT_DIRECT
   } outcome_e;

endpackage

// File: rtl/prof_owner_check.sv
module prof_owner_check #(
   parameter int               OWN_W      = 2,
   parameter logic [OWN_W-1:0] OWN_SECURE = 2'b01,
   parameter logic [OWN_W-1:0] OWN_NONSEC = 2'b11
) (
   input  logic             lvl3_present,
   input  logic             nonsecure,
   input  logic [OWN_W-1:0] buf_owner,
   input  logic             dbg_halted,
   input  logic             sec_dbg_off,
   output logic             own_fail,
   output logic             halt_sdd
);
   logic [OWN_W-1:0] want;

   if (OWN_SECURE == OWN_NONSEC) begin : g_bad_own
      $error("ownership codes for the two security states must differ");
   end

   assign want     = nonsecure ? OWN_NONSEC : OWN_SECURE;
   assign own_fail = lvl3_present && (buf_owner != want);
   assign halt_sdd = dbg_halted && sec_dbg_off;
endmodule

// File: rtl/prof_lvl2_trap.sv
module prof_lvl2_trap (
   input  logic at_lvl1,
   input  logic is_write,
   input  logic lvl2_enabled,
   input  logic lvl3_present,
   input  logic fine_trap_en,
   input  logic fine_rd_trap,
   input  logic fine_wr_trap,
   input  logic coarse_prof_trap,
   output logic fine_hit,
   output logic coarse_hit
);
   logic fine_gate;
   logic dir_bit;

   assign fine_gate  = !lvl3_present || fine_trap_en;
   assign dir_bit    = is_write ? fine_wr_trap : fine_rd_trap;
   assign fine_hit   = at_lvl1 && lvl2_enabled && fine_gate && dir_bit;
   assign coarse_hit = at_lvl1 && lvl2_enabled && coarse_prof_trap;
endmodule

// File: rtl/prof_nv_match.sv
module prof_nv_match #(
   parameter int              NV_W     = 3,
   parameter logic [NV_W-1:0] NV_CARE  = 3'b101,
   parameter logic [NV_W-1:0] NV_MATCH = 3'b101
) (
   input  logic            at_lvl1,
   input  logic            lvl2_enabled,
   input  logic [NV_W-1:0] nest_virt,
   output logic            nv_hit
);
   logic [NV_W-1:0] bit_ok;

   if ((NV_MATCH & ~NV_CARE) != '0) begin : g_bad_nv
      $error("match pattern sets a bit outside the care mask");
   end

   for (genvar i = 0; i < NV_W; i++) begin : g_bit
      if (NV_CARE[i]) begin : g_care
         assign bit_ok[i] = (nest_virt[i] == NV_MATCH[i]);
      end else begin : g_dont
         assign bit_ok[i] = 1'b1;
      end
   end

   assign nv_hit = at_lvl1 && lvl2_enabled && (&bit_ok);
endmodule

// File: rtl/prof_reg_access_decide.sv
module prof_reg_access_decide
   import prof_access_pkg::*;
#(
   parameter int                 CLASS_W    = 6,
   parameter logic [CLASS_W-1:0] TRAP_CLASS = 6'h18,
   parameter int                 OFS_W      = 12,
   parameter logic [OFS_W-1:0]   SLOT_OFS   = 12'h830,
   parameter int                 OWN_W      = 2,
   parameter int                 NV_W       = 3
) (
   input  logic [1:0]         cur_lvl,
   input  logic               is_write,
   input  logic               dbg_halted,
   input  logic               sec_dbg_off,
   input  logic               halt_undef_first,
   input  logic               lvl3_present,
   input  logic               lvl2_enabled,
   input  logic               nonsecure,
   input  logic [OWN_W-1:0]   buf_owner,
   input  logic               fine_trap_en,
   input  logic               fine_rd_trap,
   input  logic               fine_wr_trap,
   input  logic               coarse_prof_trap,
   input  logic [NV_W-1:0]    nest_virt,
   output logic               res_undef,
   output logic               res_trap_lvl2,
   output logic               res_trap_lvl3,
   output logic               res_redirect,
   output logic               res_direct,
   output logic [CLASS_W-1:0] trap_class,
   output logic [OFS_W-1:0]   redirect_ofs
);
   localparam int N_OUT = 5;

   if (TRAP_CLASS == '0) begin : g_bad_class
      $error("trap class must be nonzero");
   end
   if (SLOT_OFS == '0) begin : g_bad_ofs
      $error("slot offset must be nonzero");
   end

   lvl_e     lvl;
   outcome_e outc;
   logic     at_lvl1, at_mid;
   logic     own_fail, halt_sdd, fine_hit, coarse_hit, nv_hit;

   assign lvl     = lvl_e'(cur_lvl);
   assign at_lvl1 = (lvl == LVL_1);
   assign at_mid  = (lvl == LVL_1) || (lvl == LVL_2);

   prof_owner_check #(.OWN_W(OWN_W)) u_own (
      .lvl3_present (lvl3_present),
      .nonsecure    (nonsecure),
      .buf_owner    (buf_owner),
      .dbg_halted   (dbg_halted),
      .sec_dbg_off  (sec_dbg_off),
      .own_fail     (own_fail),
      .halt_sdd     (halt_sdd)
   );

   prof_lvl2_trap u_l2 (
      .at_lvl1          (at_lvl1),
      .is_write         (is_write),
      .lvl2_enabled     (lvl2_enabled),
      .lvl3_present     (lvl3_present),
      .fine_trap_en     (fine_trap_en),
      .fine_rd_trap     (fine_rd_trap),
      .fine_wr_trap     (fine_wr_trap),
      .coarse_prof_trap (coarse_prof_trap),
      .fine_hit         (fine_hit),
      .coarse_hit       (coarse_hit)
   );

   prof_nv_match #(.NV_W(NV_W)) u_nv (
      .at_lvl1      (at_lvl1),
      .lvl2_enabled (lvl2_enabled),
      .nest_virt    (nest_virt),
      .nv_hit       (nv_hit)
   );

   // priority chain
   always_comb begin
      if (lvl == LVL_0)                                     outc = OUT_UNDEF;
      else if (lvl == LVL_3)                                outc = OUT_DIRECT;
      else if (halt_sdd && halt_undef_first && own_fail)    outc = OUT_UNDEF;
      else if (fine_hit || coarse_hit)                      outc = OUT_TRAP2;
      else if (own_fail)                                    outc = halt_sdd ? OUT_UNDEF : OUT_TRAP3;
      else if (nv_hit)                                      outc = OUT_REDIR;
      else                                                  outc = OUT_DIRECT;
   end

   assign res_undef     = (outc == OUT_UNDEF);
   assign res_trap_lvl2 = (outc == OUT_TRAP2);
   assign res_trap_lvl3 = (outc == OUT_TRAP3);
   assign res_redirect  = (outc == OUT_REDIR);
   assign res_direct    = (outc == OUT_DIRECT);
   assign trap_class    = (res_trap_lvl2 || res_trap_lvl3) ? TRAP_CLASS : '0;
   assign redirect_ofs  = res_redirect ? SLOT_OFS : '0;

   logic [N_OUT-1:0] out_vec;
   assign out_vec = {res_undef, res_trap_lvl2, res_trap_lvl3, res_redirect, res_direct};

   always_comb begin
      if (!$isunknown({cur_lvl, outc})) begin
         assert_onehot_R10: assert ($countones(out_vec) == 1)
            else $error("outcome vector not one-hot");
         assert_lvl0_undef_R1: assert (lvl != LVL_0 || res_undef)
            else $error("level 0 access not undefined");
         assert_lvl3_direct_R2: assert (lvl != LVL_3 || res_direct)
            else $error("level 3 access not direct");
         assert_lvl2_no_l2trap_R8: assert (lvl != LVL_2 || !(res_trap_lvl2 || res_redirect))
            else $error("level-1-only outcome at level 2");
         assert_class_R9: assert ((trap_class != '0) == (res_trap_lvl2 || res_trap_lvl3))
            else $error("syndrome class out of step with trap");
         assert_slot_R7: assert ((redirect_ofs != '0) == res_redirect)
            else $error("slot offset out of step with redirect");
         assert_halt_first_R3: assert (!(at_mid && halt_sdd && halt_undef_first && own_fail) || res_undef)
            else $error("halted undefined case lost priority");
         assert_owner_after_R6: assert (!(at_mid && own_fail && !fine_hit && !coarse_hit) || res_trap_lvl3 || res_undef)
            else $error("ownership failure not reported");
      end
   end
endmodule

// File: tb/prof_reg_access_decide_tb_top.sv
module prof_reg_access_decide_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic [1:0]  cur_lvl;
   logic        is_write, dbg_halted, sec_dbg_off, halt_undef_first;
   logic        lvl3_present, lvl2_enabled, nonsecure;
   logic [1:0]  buf_owner;
   logic        fine_trap_en, fine_rd_trap, fine_wr_trap, coarse_prof_trap;
   logic [2:0]  nest_virt;
   logic        res_undef, res_trap_lvl2, res_trap_lvl3, res_redirect, res_direct;
   logic [5:0]  trap_class;
   logic [11:0] redirect_ofs;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   localparam logic [4:0] E_UNDEF = 5'b10000;
   localparam logic [4:0] E_T2    = 5'b01000;
   localparam logic [4:0] E_T3    = 5'b00100;
   localparam logic [4:0] E_RED   = 5'b00010;
   localparam logic [4:0] E_DIR   = 5'b00001;

   prof_reg_access_decide dut_i (
      .cur_lvl(cur_lvl), .is_write(is_write), .dbg_halted(dbg_halted),
      .sec_dbg_off(sec_dbg_off), .halt_undef_first(halt_undef_first),
      .lvl3_present(lvl3_present), .lvl2_enabled(lvl2_enabled),
      .nonsecure(nonsecure), .buf_owner(buf_owner),
      .fine_trap_en(fine_trap_en), .fine_rd_trap(fine_rd_trap),
      .fine_wr_trap(fine_wr_trap), .coarse_prof_trap(coarse_prof_trap),
      .nest_virt(nest_virt), .res_undef(res_undef),
      .res_trap_lvl2(res_trap_lvl2), .res_trap_lvl3(res_trap_lvl3),
      .res_redirect(res_redirect), .res_direct(res_direct),
      .trap_class(trap_class), .redirect_ofs(redirect_ofs)
   );

   // level 1, owner valid for non-secure, nothing armed
   task automatic quiet();
      cur_lvl = 2'd1; is_write = 0; dbg_halted = 0; sec_dbg_off = 0;
      halt_undef_first = 0; lvl3_present = 1; lvl2_enabled = 1; nonsecure = 1;
      buf_owner = 2'b11; fine_trap_en = 1; fine_rd_trap = 0; fine_wr_trap = 0;
      coarse_prof_trap = 0; nest_virt = 3'b000;
   endtask

   task automatic expect_out(input string req, input logic [4:0] exp);
      logic [4:0]  got;
      logic [5:0]  exp_cls;
      logic [11:0] exp_ofs;
      @(negedge clk);
      #1;
      got     = {res_undef, res_trap_lvl2, res_trap_lvl3, res_redirect, res_direct};
      exp_cls = (exp == E_T2 || exp == E_T3) ? 6'h18 : 6'h00;
      exp_ofs = (exp == E_RED) ? 12'h830 : 12'h000;
      total++;
      if (got !== exp || trap_class !== exp_cls || redirect_ofs !== exp_ofs) begin
         bad++;
         $display("FAIL %s: out=%b cls=%h ofs=%h expected out=%b cls=%h ofs=%h",
                  req, got, trap_class, redirect_ofs, exp, exp_cls, exp_ofs);
      end
   endtask

   task automatic t_idle();
      quiet(); expect_out("R10 idle level1 direct", E_DIR);
   endtask

   task automatic t_lvl0();
      quiet(); cur_lvl = 0; dbg_halted = 1; sec_dbg_off = 1; halt_undef_first = 1;
      fine_rd_trap = 1; buf_owner = 2'b00; nest_virt = 3'b101;
      expect_out("R1 level0 read", E_UNDEF);
      quiet(); cur_lvl = 0; is_write = 1;
      expect_out("R1 level0 write quiet", E_UNDEF);
   endtask

   task automatic t_lvl3();
      quiet(); cur_lvl = 3; dbg_halted = 1; sec_dbg_off = 1; halt_undef_first = 1;
      buf_owner = 2'b00; fine_rd_trap = 1; coarse_prof_trap = 1; nest_virt = 3'b111;
      expect_out("R2 level3 all armed", E_DIR);
   endtask

   task automatic t_halt_first();
      quiet(); dbg_halted = 1; sec_dbg_off = 1; halt_undef_first = 1;
      buf_owner = 2'b01; fine_rd_trap = 1; coarse_prof_trap = 1;
      expect_out("R3 halt undef beats fine trap", E_UNDEF);
      cur_lvl = 2;
      expect_out("R3 halt undef at level2", E_UNDEF);
      cur_lvl = 1; halt_undef_first = 0;
      expect_out("R3 flag clear lets fine trap win", E_T2);
   endtask

   task automatic t_fine();
      quiet(); fine_rd_trap = 1;
      expect_out("R4 read rd bit traps", E_T2);
      quiet(); fine_wr_trap = 1;
      expect_out("R4 read ignores wr bit", E_DIR);
      is_write = 1;
      expect_out("R4 write wr bit traps", E_T2);
      quiet(); is_write = 1; fine_rd_trap = 1;
      expect_out("R4 write ignores rd bit", E_DIR);
      quiet(); fine_rd_trap = 1; fine_trap_en = 0;
      expect_out("R4 gate off with level3", E_DIR);
      lvl3_present = 0;
      expect_out("R4 gate ignored without level3", E_T2);
      quiet(); fine_rd_trap = 1; lvl2_enabled = 0;
      expect_out("R4 level2 disabled", E_DIR);
   endtask

   task automatic t_coarse();
      quiet(); coarse_prof_trap = 1; buf_owner = 2'b01;
      expect_out("R5 coarse beats ownership", E_T2);
      lvl2_enabled = 0;
      expect_out("R5 coarse off when level2 disabled", E_T3);
   endtask

   task automatic t_owner();
      quiet(); nonsecure = 0; buf_owner = 2'b01;
      expect_out("R6 secure owner ok", E_DIR);
      buf_owner = 2'b11;
      expect_out("R6 secure owner bad", E_T3);
      quiet(); buf_owner = 2'b01;
      expect_out("R6 nonsecure owner bad", E_T3);
      dbg_halted = 1; sec_dbg_off = 1;
      expect_out("R6 halted secure-debug-off undef", E_UNDEF);
      quiet(); buf_owner = 2'b10; dbg_halted = 1;
      expect_out("R6 halted alone still traps", E_T3);
   endtask

   task automatic t_redirect();
      quiet(); nest_virt = 3'b101;
      expect_out("R7 nv 101 redirect", E_RED);
      nest_virt = 3'b111;
      expect_out("R7 nv 111 redirect", E_RED);
      nest_virt = 3'b100;
      expect_out("R7 nv 100 direct", E_DIR);
      nest_virt = 3'b101; lvl2_enabled = 0;
      expect_out("R7 level2 disabled no redirect", E_DIR);
      lvl2_enabled = 1; buf_owner = 2'b00;
      expect_out("R7 ownership trap beats redirect", E_T3);
   endtask

   task automatic t_lvl2();
      quiet(); cur_lvl = 2; fine_rd_trap = 1; coarse_prof_trap = 1; nest_virt = 3'b101;
      expect_out("R8 level2 ignores level2 traps and redirect", E_DIR);
      buf_owner = 2'b00;
      expect_out("R8 level2 ownership trap", E_T3);
   endtask

   task automatic t_no_lvl3();
      quiet(); lvl3_present = 0; nonsecure = 0; buf_owner = 2'b00;
      expect_out("R11 owner masked", E_DIR);
      dbg_halted = 1; sec_dbg_off = 1; halt_undef_first = 1; nonsecure = 1; buf_owner = 2'b10;
      expect_out("R11 halt case masked", E_DIR);
      nest_virt = 3'b101;
      expect_out("R11 redirect still reached", E_RED);
   endtask

   initial begin
      repeat (10000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      quiet();
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      t_idle();
      t_lvl0();
      t_lvl3();
      t_halt_first();
      t_fine();
      t_coarse();
      t_owner();
      t_redirect();
      t_lvl2();
      t_no_lvl3();
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule